// File: doc/BRIEF.md
# Pattern-Selectable Pseudo-Random Test Stream Generator

This block sits in the transmit path of a line-test channel and turns a serial payload stream into a known test stream. A small select input picks the stream: constant zeros, constant ones, or one of five maximal-length pseudo-random sequences. When the test enable is high, every payload bit that the surrounding logic marks as valid is replaced by the next bit of the chosen sequence. When the enable is low, the payload passes through unchanged.

The generator moves forward only on bits that are both valid and enabled. A channel that carries only part of a byte, or one that is enabled only in some slots, therefore still produces one unbroken sequence across the gaps. A single-shot error request flips exactly one outgoing test bit, so the far-end checker and its error counter can be tested. The output is registered and comes with its own valid flag.

Top module: `prbs_test_gen`

## Requirements
- R1: With select value 0, every valid enabled output bit is 0, unless an error flip is applied to it.
- R2: With select value 1, every valid enabled output bit is 1, unless an error flip is applied to it.
- R3: Select values 2 to 6 pick a Fibonacci shift register of length n with tap k: (9,5), (11,9), (15,14), (20,17), (23,18). The output bit is fb = s[n-1] xor s[k-1]. It is inverted for lengths 15 and 23. The state then shifts up by one with fb entering bit 0. Select value 7 behaves as the all-zero stream.
- R4: While test_en is low, a valid output bit equals the payload bit that was sampled with it.
- R5: The sequence state advances only on cycles where bit_vld and test_en are both high. On all other cycles it holds, so the sequence resumes exactly where it stopped.
- R6: One err_req pulse inverts exactly one output bit. If no valid enabled bit is present, the request stays pending and is applied to the next valid enabled bit. Further requests that arrive while one is pending merge into that one.
- R7: On reset, and in any cycle where pat_sel differs from its value in the previous cycle, the state is loaded with the all-ones seed. A valid enabled bit in that same cycle is generated from the seed.
- R8: out_vld equals bit_vld delayed by one clock. out_bit carries the result for that bit one clock after the strobe, and is 0 whenever out_vld is 0, including during reset.
- R9: Over one full period of the length-9 sequence, 511 bits starting from the seed, exactly 256 output bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_sel | input | 3 | Pattern select (0 zeros, 1 ones, 2-6 pseudo-random, 7 zeros) |
| test_en | input | 1 | Replace payload with the test pattern when high |
| bit_vld | input | 1 | A payload bit is present this cycle |
| pay_bit | input | 1 | Payload data bit |
| err_req | input | 1 | Request to invert one outgoing test bit |
| out_bit | output | 1 | Registered output bit |
| out_vld | output | 1 | Registered valid flag for out_bit |

## Verification
The bench goes after continuity across gaps. Valid strobes are dropped at random, and the enable is toggled in the middle of the sequence. A design that advanced on idle cycles or on pass-through bits would drift out of phase with the reference at once. Error requests are raised while no bit is valid, while the enable is low, and twice in a row. A design that lost the pending request, or flipped two bits, would mismatch at the next valid enabled bit. The select is changed in the middle of a run, with a valid bit in the switching cycle. A design that reseeded one cycle late would emit one bit from the old state. A full period of the length-9 sequence is counted for its 256 ones. This catches a wrong tap that the model comparison alone would never point to.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_PRBS = 5;
    localparam int LFSR_W   = 23;

    typedef enum logic [SEL_W-1:0] {
        PAT_ZERO = 3'd0,
        PAT_ONE  = 3'd1,
        PAT_P9   = 3'd2,
        PAT_P11  = 3'd3,
        PAT_P15  = 3'd4,
        PAT_P20  = 3'd5,
        PAT_P23  = 3'd6,
        PAT_RSVD = 3'd7
    } pat_e;

    localparam int FIRST_PRBS = 2;

    // Register length of pseudo-random option idx (0 = shortest).
    function automatic int prbs_len(input int idx);
        case (idx)
            0:       return 9;
            1:       return 11;
            2:       return 15;
            3:       return 20;
            default: return 23;
        endcase
    endfunction

    // Second feedback tap of option idx.
    function automatic int prbs_tap(input int idx);
        case (idx)
            0:       return 5;
            1:       return 9;
            2:       return 14;
            3:       return 17;
            default: return 18;
        endcase
    endfunction

    // Whether the output of option idx is inverted.
    function automatic bit prbs_inv(input int idx);
        return (idx == 2) || (idx == 4);
    endfunction

endpackage

// File: rtl/prbs_lfsr_step.sv
module prbs_lfsr_step
    import prbs_pkg::*;
(
    input  logic [LFSR_W-1:0] state_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [LFSR_W-1:0] next_o,
    output logic              gen_o,
    output logic              is_prbs_o
);

    logic [NUM_PRBS-1:0] fb;
    logic [NUM_PRBS-1:0] bit_out;

    // One feedback network for each polynomial option.
    for (genvar g = 0; g < NUM_PRBS; g++) begin : g_poly
        localparam int N   = prbs_len(g);
        localparam int K   = prbs_tap(g);
        localparam bit INV = prbs_inv(g);
        assign fb[g]      = state_i[N-1] ^ state_i[K-1];
        assign bit_out[g] = fb[g] ^ INV;
    end

    always_comb begin
        next_o    = state_i;
        gen_o     = 1'b0;
        is_prbs_o = 1'b0;
        case (pat_e'(sel_i))
            PAT_ONE: gen_o = 1'b1;
            PAT_P9, PAT_P11, PAT_P15, PAT_P20, PAT_P23: begin
                is_prbs_o = 1'b1;
                gen_o     = bit_out[int'(sel_i) - FIRST_PRBS];
                next_o    = {state_i[LFSR_W-2:0], fb[int'(sel_i) - FIRST_PRBS]};
            end
            default: gen_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/prbs_err_inject.sv
module prbs_err_inject (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic fire_i,
    output logic flip_o
);

    typedef struct packed {
        logic pend;
    } inj_t;

    inj_t inj_d, inj_q;

    always_comb begin
        inj_d  = inj_q;
        flip_o = fire_i & (req_i | inj_q.pend);
        if (flip_o) begin
            inj_d.pend = 1'b0;
        end else if (req_i) begin
            inj_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_q <= '0;
        end else begin
            inj_q <= inj_d;
        end
    end

    // R6: a flip consumes the request
    a_r6_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        flip_o |=> !inj_q.pend);

    // R6: an unserved request is kept
    a_r6_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !fire_i) |=> inj_q.pend);

endmodule

// File: rtl/prbs_test_gen.sv
module prbs_test_gen
    import prbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] pat_sel,
    input  logic             test_en,
    input  logic             bit_vld,
    input  logic             pay_bit,
    input  logic             err_req,
    output logic             out_bit,
    output logic             out_vld
);

    localparam logic [LFSR_W-1:0] SEED = '1;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [SEL_W-1:0]  sel;
        logic              obit;
        logic              ovld;
    } gen_t;

    gen_t gen_d, gen_q;

    logic              sel_chg;
    logic              adv;
    logic [LFSR_W-1:0] cur_state;
    logic [LFSR_W-1:0] stepped;
    logic              gen_bit;
    logic              is_prbs;
    logic              flip;

    assign sel_chg   = (pat_sel != gen_q.sel);
    assign adv       = bit_vld & test_en;
    assign cur_state = sel_chg ? SEED : gen_q.lfsr;

    prbs_lfsr_step u_step (
        .state_i   (cur_state),
        .sel_i     (pat_sel),
        .next_o    (stepped),
        .gen_o     (gen_bit),
        .is_prbs_o (is_prbs)
    );

    prbs_err_inject u_inj (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (err_req),
        .fire_i (adv),
        .flip_o (flip)
    );

    always_comb begin
        gen_d      = gen_q;
        gen_d.sel  = pat_sel;
        gen_d.lfsr = (adv && is_prbs) ? stepped : cur_state;
        gen_d.ovld = bit_vld;
        if (!bit_vld) begin
            gen_d.obit = 1'b0;
        end else if (test_en) begin
            gen_d.obit = gen_bit ^ flip;
        end else begin
            gen_d.obit = pay_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '{lfsr: SEED, sel: '0, obit: 1'b0, ovld: 1'b0};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign out_bit = gen_q.obit;
    assign out_vld = gen_q.ovld;

    // R8: valid flag is the strobe one clock later
    a_r8_vld_high: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> out_vld);
    a_r8_vld_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !out_vld);
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !out_bit);

    // R4: pass-through when disabled
    a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !test_en) |=> (out_bit == $past(pay_bit)));

    // R1 / R2: constant streams
    a_r1_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pat_sel == 3'd0 && !flip) |=> !out_bit);
    a_r2_one: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pat_sel == 3'd1 && !flip) |=> out_bit);

    // R5: state holds without a valid enabled bit
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !sel_chg) |=> $stable(gen_q.lfsr));

    // R7: select change reseeds
    a_r7_reseed: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_chg && !adv) |=> (gen_q.lfsr == SEED));

endmodule

// File: tb/sim_prbs_test_gen.sv
module sim_prbs_test_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] pat_sel;
    logic       test_en, bit_vld, pay_bit, err_req;
    logic       out_bit, out_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int unsigned m_state;
    int unsigned m_sel;
    bit          m_pend;
    int          ones_cnt;

    always #4 clk = ~clk;

    prbs_test_gen u0 (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .test_en(test_en),
        .bit_vld(bit_vld), .pay_bit(pay_bit), .err_req(err_req),
        .out_bit(out_bit), .out_vld(out_vld)
    );

    function automatic int plen(int s);
        int t[5] = '{9, 11, 15, 20, 23};
        return t[s-2];
    endfunction
    function automatic int ptap(int s);
        int t[5] = '{5, 9, 14, 18 - 1, 18};
        return t[s-2];
    endfunction
    function automatic bit pinv(int s);
        return (s == 4) || (s == 6);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp_v, input string what);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp_v);
        end
    endtask

    task automatic step(input logic v, input logic e, input logic p, input logic r,
                        input logic [2:0] s, input string tag);
        int unsigned cur;
        bit gen, fb, adv, inj, exp_bit;
        int sv;
        sv = int'(s);
        cur = (sv != int'(m_sel)) ? 32'h7F_FFFF : m_state;
        fb = 1'b0;
        gen = 1'b0;
        if (sv == 1) gen = 1'b1;
        else if (sv >= 2 && sv <= 6) begin
            fb  = cur[plen(sv)-1] ^ cur[ptap(sv)-1];
            gen = fb ^ pinv(sv);
        end
        adv = v && e;
        inj = adv && (r || m_pend);
        exp_bit = !v ? 1'b0 : (e ? (gen ^ inj) : p);
        m_pend  = (r || m_pend) && !inj;
        m_state = (adv && sv >= 2 && sv <= 6) ? (((cur << 1) | 32'(fb)) & 32'h7F_FFFF) : cur;
        m_sel   = 32'(sv);
        pat_sel = s; test_en = e; bit_vld = v; pay_bit = p; err_req = r;
        @(posedge clk);
        @(negedge clk);
        check(tag, out_vld, v, "out_vld");
        check(tag, out_bit, exp_bit, "out_bit");
        if (out_vld && out_bit) ones_cnt++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pat_sel = 3'd0; test_en = 1'b0; bit_vld = 1'b0;
        pay_bit = 1'b0; err_req = 1'b0;
        m_state = 32'h7F_FFFF; m_sel = 0; m_pend = 1'b0;
        repeat (4) @(negedge clk);
        bit_vld = 1'b1; test_en = 1'b1; pay_bit = 1'b1;
        @(negedge clk);
        check("R8", out_vld, 1'b0, "reset out_vld");
        check("R8", out_bit, 1'b0, "reset out_bit");
        bit_vld = 1'b0; test_en = 1'b0; pay_bit = 1'b0;
        rst_n = 1'b1;

        // R1: all zero
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 3'd0, "R1");
        // R2: all one
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd1, "R2");

        // R9: one full period of the length-9 sequence from the seed
        ones_cnt = 0;
        for (int i = 0; i < 511; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd2, "R3");
        checks++;
        if (ones_cnt != 256) begin
            errors++;
            $display("FAIL R9 ones in period: actual %0d expected 256", ones_cnt);
        end

        // R3 / R5: every pseudo-random option with random gaps and enable toggles
        for (int s = 2; s <= 6; s++) begin
            for (int i = 0; i < 600; i++) begin
                step(($urandom % 4) != 0, ($urandom % 8) != 0, 1'($urandom),
                     1'b0, 3'(s), "R5");
            end
        end
        // R3: reserved select acts as zeros
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 3'd7, "R3");

        // R4: pass-through with random payload
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'($urandom), 1'b0, 3'd3, "R4");

        // R6: immediate, pending over idle, pending over disabled, merged requests
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b1, 3'd3, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b1, 3'd3, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b0, 3'd3, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, "R6");
        step(1'b1, 1'b0, 1'b1, 1'b1, 3'd3, "R6");
        step(1'b1, 1'b0, 1'b0, 1'b1, 3'd3, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, "R6");
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd3, "R6");
        for (int i = 0; i < 200; i++)
            step(($urandom % 2) != 0, ($urandom % 4) != 0, 1'($urandom),
                 ($urandom % 16) == 0, 3'd5, "R6");

        // R7: select change with and without a valid bit in the switching cycle
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd4, "R7");
        step(1'b1, 1'b1, 1'b0, 1'b0, 3'd6, "R7");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd6, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b0, 3'd2, "R7");
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 3'd2, "R7");

        // R8: idle cycles keep the output low
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 3'd1, "R8");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule